// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one 16-bit instruction word into the control bundle a small register-machine core needs to execute it. The primary opcode sits in the four least significant bits. The meaning of the twelve bits above it depends on that opcode. A classifier first sorts each word into one of fifteen formats: `FMT_LDI`, `FMT_LDHI`, `FMT_ALU_RR`, `FMT_ALU_RI`, `FMT_ALU_R3`, `FMT_LOAD`, `FMT_STORE`, `FMT_BR_NZ`, `FMT_BR_Z`, `FMT_JUMP`, `FMT_CALL`, `FMT_JUMP_REG`, `FMT_CALL_REG`, `FMT_IDLE` and `FMT_BAD`. Two decoders then work from that format. One builds the sign-extended immediate. The other builds the enables, the destination index and the ALU function code. The decode is combinational from the word to the format, with no transitions between formats. A single register stage then captures the result.

The core presents a word with `in_valid`, and the decoded bundle appears on the outputs one clock later with `out_valid`. The raw register-select fields are always passed through, so the register file can start its reads without waiting on the format. Loads and stores ask the ALU to add the base register and the offset. All branch offsets arrive already sign-extended to `DATA_W` bits. Reserved words are flagged, and all of their side effects are suppressed.

Top module: `insn16_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: `out_valid` equals `in_valid` of the previous cycle, and every other output is zero in a cycle where `out_valid` is low.
- R3: For every accepted word, `src_a` = bits [7:4] and `src_b` = bits [11:8].
- R4: Opcode 0000 (load-immediate) and opcode 0001 (high-byte insert) produce the following outputs: `reg_we`=1, `use_imm`=1, `dst` = bits [7:4], and `imm` = bits [15:8] sign-extended. `alu_fn` is 0x0 (pass operand b) for opcode 0000 and 0x7 (keep low byte of a, b shifted into high byte) for opcode 0001.
- R5: Opcode 0010 produces `reg_we`=1, `dst` = bits [7:4], `alu_fn` = bits [15:12], `use_imm`=0 and `imm`=0.
- R6: Opcode 0011 produces `reg_we`=1, `dst` = bits [7:4], `alu_fn` = bits [11:8], `use_imm`=1, and `imm` = bits [15:12] sign-extended.
- R7: Opcodes 01cc produce `reg_we`=1, `dst` = cc (registers 0 to 3), `alu_fn` = bits [15:12], `use_imm`=0 and `imm`=0.
- R8: Opcode 1000 (load) gives `mem_rd`=1, `reg_we`=1 and `dst` = bits [7:4]. Opcode 1001 (store) gives `mem_wr`=1 with `reg_we`=0 and `dst`=0. Both give `alu_fn`=0x4 (add), `use_imm`=1, and `imm` = bits [15:12] sign-extended.
- R9: Opcode 1010 gives `branch`=1 and `br_cond`=01 (taken if register a is nonzero). Opcode 1011 gives `branch`=1 and `br_cond`=10 (taken if register a is zero). For both, `imm` = bits [15:8] sign-extended.
- R10: Opcodes 1100 and 1101 give `branch`=1, `br_cond`=00 and `imm` = bits [15:4] sign-extended. Opcode 1101 also gives `link`=1, `reg_we`=1 and `dst`=14.
- R11: Opcode 1110 with bits [15:12] = 0000 gives `branch`=1, `br_reg`=1, `br_cond`=00 and `imm`=0. With bits [15:12] = 0001 it does the same and also gives `link`=1, `reg_we`=1 and `dst`=14.
- R12: Opcode 1110 with bits [15:12] = 0010 is a no-op. It gives `illegal`=0, and every enable, `dst`, `alu_fn` and `imm` is zero.
- R13: Opcode 1110 with bits [15:12] of 0011 or above, and every word with opcode 1111, gives `illegal`=1 with every other decoded output zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `instr` holds a word to decode this cycle |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded bundle is valid |
| src_a | output | 4 | Register-a select, bits [7:4] |
| src_b | output | 4 | Register-b select, bits [11:8] |
| dst | output | 4 | Destination register index |
| alu_fn | output | 4 | ALU function code |
| use_imm | output | 1 | ALU operand b comes from `imm` |
| imm | output | DATA_W | Sign-extended immediate or branch offset |
| reg_we | output | 1 | Register write enable |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| branch | output | 1 | Control transfer |
| br_cond | output | 2 | 00 always, 01 if nonzero, 10 if zero |
| br_reg | output | 1 | Target is register b rather than PC-relative |
| link | output | 1 | Save return address |
| illegal | output | 1 | Reserved or undefined encoding |

## Verification
The assertions assume that `in_valid` and `instr` carry known values at every rising edge after reset is released. They also assume that reset is applied before the first word. The invariants they check do not depend on the word: memory read and write are never both set, a link always writes register 14, and an illegal word drives no enables. These invariants therefore cover any legal sequence. The stimulus keeps to these assumptions. It drives both inputs from a defined state at a falling edge while reset is still held. It then sweeps every one of the 65536 words back to back, with idle cycles before and after the sweep.

// File: rtl/insn16_pkg.sv
package insn16_pkg;

    localparam int OPC_W = 4;
    localparam int REG_W = 4;
    localparam int FN_W  = 4;

    typedef enum logic [3:0] {
        FMT_LDI,
        FMT_LDHI,
        FMT_ALU_RR,
        FMT_ALU_RI,
        FMT_ALU_R3,
        FMT_LOAD,
        FMT_STORE,
        FMT_BR_NZ,
        FMT_BR_Z,
        FMT_JUMP,
        FMT_CALL,
        FMT_JUMP_REG,
        FMT_CALL_REG,
        FMT_IDLE,
        FMT_BAD
    } fmt_e;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_NZ     = 2'b01,
        COND_Z      = 2'b10
    } cond_e;

    localparam logic [FN_W-1:0]  FN_PASS   = 4'h0;
    localparam logic [FN_W-1:0]  FN_ADD    = 4'h4;
    localparam logic [FN_W-1:0]  FN_HIBYTE = 4'h7;
    localparam logic [REG_W-1:0] LINK_IDX  = 4'd14;

    typedef struct packed {
        logic              illegal;
        logic              reg_we;
        logic              mem_rd;
        logic              mem_wr;
        logic              branch;
        cond_e             cond;
        logic              br_reg;
        logic              link;
        logic              use_imm;
        logic [REG_W-1:0]  rd;
        logic [FN_W-1:0]   alu_fn;
    } ctrl_t;

endpackage

// File: rtl/insn16_classify.sv
module insn16_classify
    import insn16_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [3:0]       sub,
    output fmt_e             fmt
);

    fmt_e sys_fmt;

    // Sub-decode of the system opcode (1110) on the top nibble
    always_comb begin
        unique case (sub)
            4'b0000: sys_fmt = FMT_JUMP_REG;
            4'b0001: sys_fmt = FMT_CALL_REG;
            4'b0010: sys_fmt = FMT_IDLE;
            default: sys_fmt = FMT_BAD;
        endcase
    end

    always_comb begin
        unique casez (opc)
            4'b0000: fmt = FMT_LDI;
            4'b0001: fmt = FMT_LDHI;
            4'b0010: fmt = FMT_ALU_RR;
            4'b0011: fmt = FMT_ALU_RI;
            4'b01??: fmt = FMT_ALU_R3;
            4'b1000: fmt = FMT_LOAD;
            4'b1001: fmt = FMT_STORE;
            4'b1010: fmt = FMT_BR_NZ;
            4'b1011: fmt = FMT_BR_Z;
            4'b1100: fmt = FMT_JUMP;
            4'b1101: fmt = FMT_CALL;
            4'b1110: fmt = sys_fmt;
            default: fmt = FMT_BAD;
        endcase
    end

    // R13: opcode 1111 never maps to a legal format
    always_comb begin
        if (opc == 4'b1111)
            p_opc15_bad_r13: assert (fmt == FMT_BAD);
    end

endmodule

// File: rtl/insn16_immgen.sv
module insn16_immgen
    import insn16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fmt_e              fmt,
    input  logic [11:0]       upper,
    output logic [DATA_W-1:0] imm
);

    localparam int EXT4  = DATA_W - 4;
    localparam int EXT8  = DATA_W - 8;
    localparam int EXT12 = DATA_W - 12;

    logic [DATA_W-1:0] sx4;
    logic [DATA_W-1:0] sx8;
    logic [DATA_W-1:0] sx12;

    assign sx4  = {{EXT4{upper[11]}},  upper[11:8]};
    assign sx8  = {{EXT8{upper[11]}},  upper[11:4]};
    assign sx12 = {{EXT12{upper[11]}}, upper};

    always_comb begin
        unique case (fmt)
            FMT_LDI, FMT_LDHI, FMT_BR_NZ, FMT_BR_Z: imm = sx8;
            FMT_ALU_RI, FMT_LOAD, FMT_STORE:        imm = sx4;
            FMT_JUMP, FMT_CALL:                     imm = sx12;
            default:                                imm = '0;
        endcase
    end

endmodule

// File: rtl/insn16_ctrl.sv
module insn16_ctrl
    import insn16_pkg::*;
(
    input  fmt_e             fmt,
    input  logic [FN_W-1:0]  fn_hi,
    input  logic [FN_W-1:0]  fn_mid,
    input  logic [REG_W-1:0] ra,
    input  logic [1:0]       cc,
    output ctrl_t            ctl
);

    localparam int PAD_W = REG_W - 2;

    always_comb begin
        ctl      = '0;
        ctl.cond = COND_ALWAYS;
        unique case (fmt)
            FMT_LDI: begin
                ctl.reg_we  = 1'b1;
                ctl.rd      = ra;
                ctl.alu_fn  = FN_PASS;
                ctl.use_imm = 1'b1;
            end
            FMT_LDHI: begin
                ctl.reg_we  = 1'b1;
                ctl.rd      = ra;
                ctl.alu_fn  = FN_HIBYTE;
                ctl.use_imm = 1'b1;
            end
            FMT_ALU_RR: begin
                ctl.reg_we  = 1'b1;
                ctl.rd      = ra;
                ctl.alu_fn  = fn_hi;
            end
            FMT_ALU_RI: begin
                ctl.reg_we  = 1'b1;
                ctl.rd      = ra;
                ctl.alu_fn  = fn_mid;
                ctl.use_imm = 1'b1;
            end
            FMT_ALU_R3: begin
                ctl.reg_we  = 1'b1;
                ctl.rd      = {{PAD_W{1'b0}}, cc};
                ctl.alu_fn  = fn_hi;
            end
            FMT_LOAD: begin
                ctl.reg_we  = 1'b1;
                ctl.mem_rd  = 1'b1;
                ctl.rd      = ra;
                ctl.alu_fn  = FN_ADD;
                ctl.use_imm = 1'b1;
            end
            FMT_STORE: begin
                ctl.mem_wr  = 1'b1;
                ctl.alu_fn  = FN_ADD;
                ctl.use_imm = 1'b1;
            end
            FMT_BR_NZ: begin
                ctl.branch  = 1'b1;
                ctl.cond    = COND_NZ;
            end
            FMT_BR_Z: begin
                ctl.branch  = 1'b1;
                ctl.cond    = COND_Z;
            end
            FMT_JUMP: begin
                ctl.branch  = 1'b1;
            end
            FMT_CALL: begin
                ctl.branch  = 1'b1;
                ctl.link    = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.rd      = LINK_IDX;
            end
            FMT_JUMP_REG: begin
                ctl.branch  = 1'b1;
                ctl.br_reg  = 1'b1;
            end
            FMT_CALL_REG: begin
                ctl.branch  = 1'b1;
                ctl.br_reg  = 1'b1;
                ctl.link    = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.rd      = LINK_IDX;
            end
            FMT_IDLE: begin
                ctl = ctl;
            end
            FMT_BAD: begin
                ctl.illegal = 1'b1;
            end
            default: begin
                ctl.illegal = 1'b1;
            end
        endcase
    end

    // R8: a memory access never reads and writes at once
    always_comb begin
        p_mem_excl_r8: assert (!(ctl.mem_rd && ctl.mem_wr));
    end

endmodule

// File: rtl/insn16_decoder.sv
module insn16_decoder
    import insn16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       instr,
    output logic              out_valid,
    output logic [3:0]        src_a,
    output logic [3:0]        src_b,
    output logic [3:0]        dst,
    output logic [3:0]        alu_fn,
    output logic              use_imm,
    output logic [DATA_W-1:0] imm,
    output logic              reg_we,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              branch,
    output logic [1:0]        br_cond,
    output logic              br_reg,
    output logic              link,
    output logic              illegal
);

    fmt_e              fmt;
    ctrl_t             ctl;
    logic [DATA_W-1:0] imm_d;

    insn16_classify u_classify (
        .opc (instr[3:0]),
        .sub (instr[15:12]),
        .fmt (fmt)
    );

    insn16_immgen #(.DATA_W(DATA_W)) u_immgen (
        .fmt   (fmt),
        .upper (instr[15:4]),
        .imm   (imm_d)
    );

    insn16_ctrl u_ctrl (
        .fmt    (fmt),
        .fn_hi  (instr[15:12]),
        .fn_mid (instr[11:8]),
        .ra     (instr[7:4]),
        .cc     (instr[1:0]),
        .ctl    (ctl)
    );

    // Single output register stage; idle cycles clear the whole bundle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            src_a     <= '0;
            src_b     <= '0;
            dst       <= '0;
            alu_fn    <= '0;
            use_imm   <= 1'b0;
            imm       <= '0;
            reg_we    <= 1'b0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            branch    <= 1'b0;
            br_cond   <= '0;
            br_reg    <= 1'b0;
            link      <= 1'b0;
            illegal   <= 1'b0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            src_a     <= instr[7:4];
            src_b     <= instr[11:8];
            dst       <= ctl.rd;
            alu_fn    <= ctl.alu_fn;
            use_imm   <= ctl.use_imm;
            imm       <= imm_d;
            reg_we    <= ctl.reg_we;
            mem_rd    <= ctl.mem_rd;
            mem_wr    <= ctl.mem_wr;
            branch    <= ctl.branch;
            br_cond   <= ctl.cond;
            br_reg    <= ctl.br_reg;
            link      <= ctl.link;
            illegal   <= ctl.illegal;
        end else begin
            out_valid <= 1'b0;
            src_a     <= '0;
            src_b     <= '0;
            dst       <= '0;
            alu_fn    <= '0;
            use_imm   <= 1'b0;
            imm       <= '0;
            reg_we    <= 1'b0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            branch    <= 1'b0;
            br_cond   <= '0;
            br_reg    <= 1'b0;
            link      <= 1'b0;
            illegal   <= 1'b0;
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(reg_we || mem_rd || mem_wr || branch || link || illegal));

    p_rs_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (src_a == $past(instr[7:4])) && (src_b == $past(instr[11:8])));

    p_mem_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    p_link_r14_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link |-> (reg_we && branch && dst == LINK_IDX));

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(reg_we || mem_rd || mem_wr || branch || link));

    p_store_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !reg_we);

endmodule

// File: tb/insn16_decoder_tb_top.sv
module insn16_decoder_tb_top;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [15:0]       instr;
    logic              out_valid;
    logic [3:0]        src_a, src_b, dst, alu_fn;
    logic              use_imm;
    logic [DATA_W-1:0] imm;
    logic              reg_we, mem_rd, mem_wr, branch, br_reg, link, illegal;
    logic [1:0]        br_cond;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    insn16_decoder #(.DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .out_valid (out_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .dst       (dst),
        .alu_fn    (alu_fn),
        .use_imm   (use_imm),
        .imm       (imm),
        .reg_we    (reg_we),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .branch    (branch),
        .br_cond   (br_cond),
        .br_reg    (br_reg),
        .link      (link),
        .illegal   (illegal)
    );

    // {illegal, reg_we, mem_rd, mem_wr, branch, br_cond, br_reg, link, use_imm, dst, alu_fn, imm}
    function automatic logic [33:0] got_vec();
        return {illegal, reg_we, mem_rd, mem_wr, branch, br_cond, br_reg, link,
                use_imm, dst, alu_fn, imm};
    endfunction

    function automatic logic [15:0] sext(input int val, input int bits);
        int v;
        v = (val >= (1 << (bits - 1))) ? val - (1 << bits) : val;
        return 16'(v);
    endfunction

    function automatic string req_of(input logic [15:0] w);
        case (w[3:0])
            4'h0, 4'h1:             return "R4";
            4'h2:                   return "R5";
            4'h3:                   return "R6";
            4'h4, 4'h5, 4'h6, 4'h7: return "R7";
            4'h8, 4'h9:             return "R8";
            4'hA, 4'hB:             return "R9";
            4'hC, 4'hD:             return "R10";
            4'hE: begin
                if (w[15:12] <= 4'h1)      return "R11";
                else if (w[15:12] == 4'h2) return "R12";
                else                       return "R13";
            end
            default:                return "R13";
        endcase
    endfunction

    function automatic logic [33:0] exp_vec(input logic [15:0] w);
        logic        e_ill, e_we, e_rd, e_wr, e_br, e_breg, e_lnk, e_ui;
        logic [1:0]  e_cond;
        logic [3:0]  e_dst, e_fn;
        logic [15:0] e_imm;
        int hi4, mid4, ra, b8, u12;
        hi4  = int'(w[15:12]);
        mid4 = int'(w[11:8]);
        ra   = int'(w[7:4]);
        b8   = int'(w[15:8]);
        u12  = int'(w[15:4]);
        {e_ill, e_we, e_rd, e_wr, e_br, e_breg, e_lnk, e_ui} = '0;
        e_cond = 2'b00; e_dst = '0; e_fn = '0; e_imm = '0;
        case (w[3:0])
            4'h0, 4'h1: begin // R4
                e_we = 1; e_ui = 1; e_dst = 4'(ra);
                e_fn = (w[0]) ? 4'h7 : 4'h0;
                e_imm = sext(b8, 8);
            end
            4'h2: begin // R5
                e_we = 1; e_dst = 4'(ra); e_fn = 4'(hi4);
            end
            4'h3: begin // R6
                e_we = 1; e_dst = 4'(ra); e_fn = 4'(mid4); e_ui = 1;
                e_imm = sext(hi4, 4);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin // R7
                e_we = 1; e_dst = 4'(int'(w[3:0]) - 4); e_fn = 4'(hi4);
            end
            4'h8, 4'h9: begin // R8
                e_fn = 4'h4; e_ui = 1; e_imm = sext(hi4, 4);
                if (w[0]) e_wr = 1;
                else begin e_rd = 1; e_we = 1; e_dst = 4'(ra); end
            end
            4'hA, 4'hB: begin // R9
                e_br = 1; e_cond = w[0] ? 2'b10 : 2'b01;
                e_imm = sext(b8, 8);
            end
            4'hC, 4'hD: begin // R10
                e_br = 1; e_imm = sext(u12, 12);
                if (w[0]) begin e_lnk = 1; e_we = 1; e_dst = 4'd14; end
            end
            4'hE: begin
                if (hi4 <= 1) begin // R11
                    e_br = 1; e_breg = 1;
                    if (hi4 == 1) begin e_lnk = 1; e_we = 1; e_dst = 4'd14; end
                end else if (hi4 != 2) begin // R13
                    e_ill = 1;
                end
            end
            default: e_ill = 1; // R13
        endcase
        return {e_ill, e_we, e_rd, e_wr, e_br, e_cond, e_breg, e_lnk, e_ui,
                e_dst, e_fn, e_imm};
    endfunction

    task automatic check_quiet(input string req);
        checks++;
        if (out_valid !== 1'b0 || got_vec() !== 34'h0 || src_a !== 4'h0 || src_b !== 4'h0) begin
            fails++;
            $display("FAIL %s: quiet outputs actual valid=%b vec=%h expected valid=0 vec=0",
                     req, out_valid, got_vec());
        end
    endtask

    task automatic check_word(input logic [15:0] w);
        logic [33:0] e;
        e = exp_vec(w);
        checks++;
        if (out_valid !== 1'b1 || src_a !== w[7:4] || src_b !== w[11:8]) begin
            fails++;
            $display("FAIL R3: word %h actual valid=%b a=%h b=%h expected valid=1 a=%h b=%h",
                     w, out_valid, src_a, src_b, w[7:4], w[11:8]);
        end
        checks++;
        if (got_vec() !== e) begin
            fails++;
            $display("FAIL %s: word %h actual %h expected %h", req_of(w), w, got_vec(), e);
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        instr    = 16'h0000;
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        instr    = 16'h5AD3;
        @(negedge clk);
        check_quiet("R1");
        rst_n    = 1'b1;
        in_valid = 1'b0;
        instr    = 16'h1234;
        @(negedge clk);
        check_quiet("R2");
        for (int i = 0; i < 65536; i++) begin
            in_valid = 1'b1;
            instr    = 16'(i);
            @(negedge clk);
            check_word(16'(i));
        end
        in_valid = 1'b0;
        instr    = 16'hFFFF;
        @(negedge clk);
        check_quiet("R2");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule